// File: doc/BRIEF.md
# USB Token Address and Endpoint Decoder

This block sits behind the token decoder of a full-speed USB device controller. For every token it gets, it decides which endpoint FIFO, if any, takes part in the data stage that follows. First it compares the 7-bit address in the token with the device's programmed function address. If they are equal, it compares the 4-bit endpoint number in the token with all seven endpoint control registers at the same time. The result is a one-hot FIFO select and a hit flag.

The FIFOs form a split bank. One bidirectional control FIFO is paired with three transmit FIFOs and three receive FIFOs. Every FIFO has its own endpoint register, and all of them share one function address. The token direction limits which FIFOs may respond:
- An IN token can only reach transmit FIFOs.
- An OUT or SETUP token can only reach receive FIFOs.
- The control FIFO answers both directions through two separate enables.

Turning on both enables of the control FIFO at once is a configuration error. The block reports it on a separate output.

Top module: `usb_ep_decode`

## Requirements
- R1: After reset, `fifo_sel` is all zeros and `hit` is low.
- R2: A token whose address differs from `dev_addr` selects no FIFO and leaves `hit` low.
- R3: A matching token selects exactly the FIFO of the matching register. Bit 0 of `fifo_sel` is the control FIFO. Bits 1 to 6 are, in this order: transmit 1, receive 1, transmit 2, receive 2, transmit 3, receive 3. The endpoint number of register i is `ep_num[4*i+3:4*i]`.
- R4: A disabled register never matches. Register k (k = 1..6) is enabled by `ep_en[k-1]`. The control FIFO is enabled for IN by `ctl_tx_en` and for OUT/SETUP by `ctl_rx_en`.
- R5: An IN token (PID 4'b1001) never selects a receive FIFO (bits 2, 4, 6). An OUT (4'b0001) or SETUP (4'b1101) token never selects a transmit FIFO (bits 1, 3, 5).
- R6: Any other PID, for example SOF (4'b0101), selects no FIFO.
- R7: If several registers match in the same direction, only the lowest-numbered one is selected. `fifo_sel` is never more than one-hot.
- R8: The result appears on the first clock edge that samples `tok_valid` high. It then holds unchanged until the next strobe, even if the configuration inputs change.
- R9: `cfg_err` is high whenever `ctl_tx_en` and `ctl_rx_en` are both high. While it is high, the control FIFO is never selected.
- R10: `hit` is high exactly when `fifo_sel` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | One-cycle strobe for a decoded token |
| tok_pid | input | 4 | Token PID |
| tok_addr | input | 7 | Function address field of the token |
| tok_ep | input | 4 | Endpoint field of the token |
| dev_addr | input | 7 | Programmed function address |
| ctl_tx_en | input | 1 | Control FIFO enabled for IN |
| ctl_rx_en | input | 1 | Control FIFO enabled for OUT/SETUP |
| ep_en | input | 6 | Enables of endpoint registers 1..6 |
| ep_num | input | 28 | Endpoint numbers of registers 0..6, 4 bits each |
| fifo_sel | output | 7 | One-hot registered FIFO select |
| hit | output | 1 | Registered match flag |
| cfg_err | output | 1 | Both control FIFO directions enabled |

## Verification
The bench programs two transmit registers with the same endpoint number. A design without priority would then raise two select bits; one with the wrong priority order would pick the higher register. It sends tokens whose endpoint number is held only by a register of the opposite direction. A decoder that ignores the token direction would select a FIFO the host is not using. It also checks three more cases:
- A non-data PID and a wrong address: a design that skips either filter would claim the packet.
- Changes to the configuration between strobes: a combinational or re-evaluating output would move when it should hold.
- Both control enables set: the control FIFO must stay unselected while `cfg_err` is reported.

// File: rtl/usb_ep_decode.sv
module usb_ep_decode #(
  parameter int ADDR_W  = 7,
  parameter int EP_W    = 4,
  parameter int N_PAIRS = 3,
  localparam int N_REG  = 1 + 2 * N_PAIRS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tok_valid,
  input  logic [3:0]             tok_pid,
  input  logic [ADDR_W-1:0]      tok_addr,
  input  logic [EP_W-1:0]        tok_ep,
  input  logic [ADDR_W-1:0]      dev_addr,
  input  logic                   ctl_tx_en,
  input  logic                   ctl_rx_en,
  input  logic [N_REG-2:0]       ep_en,
  input  logic [N_REG*EP_W-1:0]  ep_num,
  output logic [N_REG-1:0]       fifo_sel,
  output logic                   hit,
  output logic                   cfg_err
);

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_SETUP = 4'b1101;

  logic             pid_in, pid_rx, addr_ok;
  logic [N_REG-1:0] cand, pick;

  assign pid_in  = (tok_pid == PID_IN);
  assign pid_rx  = (tok_pid == PID_OUT) || (tok_pid == PID_SETUP);
  assign addr_ok = (tok_addr == dev_addr);
  assign cfg_err = ctl_tx_en & ctl_rx_en;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic num_ok;
    assign num_ok = (ep_num[i*EP_W +: EP_W] == tok_ep);
    if (i == 0) begin : g_ctl
      assign cand[i] = num_ok & ~cfg_err &
                       ((pid_in & ctl_tx_en) | (pid_rx & ctl_rx_en));
    end else if (i % 2 == 1) begin : g_tx
      assign cand[i] = num_ok & ep_en[i-1] & pid_in;
    end else begin : g_rx
      assign cand[i] = num_ok & ep_en[i-1] & pid_rx;
      a_r5_in_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && pid_in) |=> !fifo_sel[i]);
    end
    if (i % 2 == 1) begin : g_txchk
      a_r5_out_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && pid_rx) |=> !fifo_sel[i]);
    end
  end

  assign pick = addr_ok ? (cand & (~cand + 1'b1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_sel <= '0;
      hit      <= 1'b0;
    end else if (tok_valid) begin
      fifo_sel <= pick;
      hit      <= |pick;
    end
  end

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_sel));
  a_r2_addr_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_addr != dev_addr) |=> (!hit && fifo_sel == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> $stable(fifo_sel));
  a_r9_ctl_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && cfg_err) |=> !fifo_sel[0]);
  a_r10_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (fifo_sel != '0));

endmodule

// File: tb/usb_ep_decode_tb.sv
module usb_ep_decode_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tok_valid = 0;
  logic [3:0]  tok_pid = 0;
  logic [6:0]  tok_addr = 0;
  logic [3:0]  tok_ep = 0;
  logic [6:0]  dev_addr = 7'h2A;
  logic        ctl_tx_en = 0;
  logic        ctl_rx_en = 1;
  logic [5:0]  ep_en = 6'h3F;
  logic [27:0] ep_num;
  logic [6:0]  fifo_sel;
  logic        hit, cfg_err;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [3:0] IN = 4'b1001, OUT = 4'b0001, SETUP = 4'b1101, SOF = 4'b0101;

  always #10 clk = ~clk;

  usb_ep_decode u_dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
    .tok_addr(tok_addr), .tok_ep(tok_ep), .dev_addr(dev_addr),
    .ctl_tx_en(ctl_tx_en), .ctl_rx_en(ctl_rx_en), .ep_en(ep_en),
    .ep_num(ep_num), .fifo_sel(fifo_sel), .hit(hit), .cfg_err(cfg_err));

  task automatic check(string req, logic [6:0] exp_sel);
    checks++;
    if (fifo_sel !== exp_sel || hit !== (exp_sel != 0)) begin
      fails++;
      $display("FAIL %s: sel=%b hit=%b, expected sel=%b hit=%b",
               req, fifo_sel, hit, exp_sel, exp_sel != 0);
    end
  endtask

  task automatic send(logic [3:0] pid, logic [6:0] addr, logic [3:0] ep);
    @(negedge clk);
    tok_pid = pid; tok_addr = addr; tok_ep = ep; tok_valid = 1;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 reset", 7'b0);
  endtask

  task automatic t_route;
    send(IN, 7'h2A, 4'd1);    check("R3 IN ep1 -> tx1", 7'b0000010);
    send(OUT, 7'h2A, 4'd1);   check("R3 OUT ep1 -> rx1", 7'b0000100);
    send(OUT, 7'h2A, 4'd3);   check("R3 OUT ep3 -> rx2", 7'b0010000);
    send(SETUP, 7'h2A, 4'd5); check("R3 SETUP ep5 -> rx3", 7'b1000000);
    send(SETUP, 7'h2A, 4'd0); check("R3 SETUP ep0 -> ctl", 7'b0000001);
    send(IN, 7'h2A, 4'd9);    check("R3 IN unknown ep", 7'b0);
  endtask

  task automatic t_addr;
    send(IN, 7'h2B, 4'd1);    check("R2 addr miss", 7'b0);
    send(OUT, 7'h00, 4'd0);   check("R2 addr zero miss", 7'b0);
  endtask

  task automatic t_dir;
    send(IN, 7'h2A, 4'd3);    check("R5 IN on rx-only ep", 7'b0);
    send(OUT, 7'h2A, 4'd2);   check("R5 OUT on tx-only ep", 7'b0);
    send(IN, 7'h2A, 4'd0);    check("R4 IN ep0 ctl tx disabled", 7'b0);
  endtask

  task automatic t_pid;
    send(SOF, 7'h2A, 4'd1);   check("R6 SOF ignored", 7'b0);
    send(4'b0010, 7'h2A, 4'd1); check("R6 ACK ignored", 7'b0);
  endtask

  task automatic t_prio;
    send(IN, 7'h2A, 4'd2);    check("R7 lowest wins", 7'b0001000);
    ep_en[2] = 0;
    send(IN, 7'h2A, 4'd2);    check("R4 R7 next after disable", 7'b0100000);
    ep_en[4] = 0;
    send(IN, 7'h2A, 4'd2);    check("R4 both disabled", 7'b0);
    ep_en = 6'h3F;
    ep_en[0] = 0;
    send(IN, 7'h2A, 4'd1);    check("R4 tx1 disabled", 7'b0);
    ep_en = 6'h3F;
  endtask

  task automatic t_hold;
    send(OUT, 7'h2A, 4'd1);   check("R8 captured", 7'b0000100);
    ep_en = 6'h00; dev_addr = 7'h11;
    tok_pid = IN; tok_addr = 7'h00; tok_ep = 4'd7;
    repeat (3) @(negedge clk);
    check("R8 held without strobe", 7'b0000100);
    ep_en = 6'h3F; dev_addr = 7'h2A;
    send(IN, 7'h2A, 4'd9);    check("R8 cleared by next strobe", 7'b0);
  endtask

  task automatic t_cfg;
    checks++;
    if (cfg_err !== 1'b0) begin fails++; $display("FAIL R9 cfg_err=%b expected 0", cfg_err); end
    ctl_tx_en = 1;
    #1;
    checks++;
    if (cfg_err !== 1'b1) begin fails++; $display("FAIL R9 cfg_err=%b expected 1", cfg_err); end
    send(SETUP, 7'h2A, 4'd0); check("R9 ctl blocked rx", 7'b0);
    send(IN, 7'h2A, 4'd0);    check("R9 ctl blocked tx", 7'b0);
    ctl_rx_en = 0;
    send(IN, 7'h2A, 4'd0);    check("R3 IN ep0 -> ctl", 7'b0000001);
    send(OUT, 7'h2A, 4'd0);   check("R4 OUT ep0 ctl rx disabled", 7'b0);
  endtask

  initial begin
    ep_num = {4'd5, 4'd2, 4'd3, 4'd2, 4'd1, 4'd1, 4'd0};
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_route;
    t_addr;
    t_dir;
    t_pid;
    t_prio;
    t_hold;
    t_cfg;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule